// File: doc/BRIEF.md
# Repeating block I/O transfer sequencer

This block runs, one clock per T-state, the two decrementing repeat-block I/O instructions of an 8-bit CPU once the decoder has recognised them. A one-cycle `start` with a direction bit loads the pointer (HL), the byte counter (B), the port register (C) and the current flag byte. The block then repeats transfers until the counter reaches zero. In the inbound direction each transfer reads a port and writes the byte to memory. In the outbound direction it reads memory and writes the byte to a port. After every transfer both the pointer and the counter step down by one.

Each iteration walks through named phases: `S_PFX1` (4 T), `S_PFX2` (5 T, the two re-fetch slots), `S_XRD` (3 T, read of the source), `S_XWR` (4 T, write of the destination), then `S_GAP` (5 T) when bytes remain. In `S_GAP` two refresh cycles are driven and the last T-state is the interrupt window. The transitions are these:
- `S_IDLE` goes to `S_PFX1` on start.
- Each phase goes to the next one at its last T-state.
- `S_XWR` goes to `S_IDLE` when the counter was 1, and to `S_GAP` otherwise.
- `S_GAP` goes to `S_IDLE` when an interrupt is requested in the window, and to `S_PFX1` otherwise.

When the block stops for an interrupt it raises `restart`, so the decoder re-issues the instruction later with the updated HL and B.

Top module: `blkio_seq`

## Requirements
- R1: With `dir_in`=1 (inbound), each iteration holds `io_rd` high for 3 cycles at address {B,C}. It then holds `mem_wr` high for 4 cycles at address HL, and `data_out` carries the byte on `data_in` in the last `io_rd` cycle.
- R2: With `dir_in`=0 (outbound), each iteration holds `mem_rd` for 3 cycles at HL. It then holds `io_wr` for 4 cycles at {B,C}, carrying the byte read from memory. At most one of the strobes `io_rd`, `io_wr`, `mem_rd`, `mem_wr` and `refresh` is high in any cycle.
- R3: After every transfer HL and B each decrease by one, modulo 2^16 and 2^8. The next iteration uses the new values. After completion `hl_out` is HL−n and `b_out` is 0.
- R4: B is tested after it is decremented, so an initial B of k performs k transfers and an initial B of 0 performs 256.
- R5: An iteration that leaves B non-zero lasts 21 cycles and the final one lasts 16. `busy` is high from the cycle after `start` through the `done` cycle, which is 21·(n−1)+16 cycles.
- R6: `refresh` is high for exactly 2 cycles between consecutive iterations and never after the final transfer.
- R7: `iter_end` marks the last cycle of each gap. If `int_req` is high there, `restart` pulses in that cycle and the block stops with HL and B already updated. `int_req` has no effect at any other time, including during a final iteration.
- R8: When the block stops, `flags_out` bit 6 (zero) equals (B==0) and bit 1 (subtract) is 1. Every other bit, including carry at bit 0, equals `flags_in`.
- R9: `done` is a one-cycle pulse in the last cycle of the final iteration, and `busy` is low in the next cycle.
- R10: A `start` while `busy` is high is ignored: the running sequence's transfers and its final values are unchanged.
- R11: After reset the block is idle: `busy`, `done`, `restart` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Decoded start pulse |
| dir_in | input | 1 | 1 = port to memory, 0 = memory to port |
| hl_in | input | 16 | Initial memory pointer |
| b_in | input | 8 | Initial byte counter |
| c_in | input | 8 | Port number |
| flags_in | input | 8 | Flag byte before the instruction |
| int_req | input | 1 | Pending maskable interrupt |
| data_in | input | 8 | Read data from the port or memory |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| refresh | output | 1 | Refresh cycle indication |
| io_addr | output | 16 | Port address {B,C} |
| mem_addr | output | 16 | Memory address HL |
| data_out | output | 8 | Write data (byte captured in the read phase) |
| busy | output | 1 | Sequence in progress |
| iter_end | output | 1 | Interrupt window, last cycle of a gap |
| done | output | 1 | Last cycle of the final iteration |
| restart | output | 1 | Stopped for an interrupt; re-execute later |
| hl_out | output | 16 | Current or final HL |
| b_out | output | 8 | Current or final B |
| flags_out | output | 8 | Resulting flag byte |

## Verification
Both directions are run with small counts and different pointers and ports. This shows whether reads and writes land on the right bus with the right address, and whether the written byte is the one read in the same iteration. A count of 1 isolates the short final iteration with no gap. A count of 0 shows the post-decrement test giving 256 transfers. A pointer near zero exposes wrap-around. An interrupt held high separates a stop in a gap window, followed by a resumed run from the returned registers, from a request on a single-byte run, where it must be ignored. A start issued mid-run shows it has no effect on the bus traffic or the final values.

// File: rtl/blkio_pkg.sv
package blkio_pkg;
    localparam int DW      = 8;
    localparam int AW      = 16;
    localparam int T_PFX1  = 4;
    localparam int T_PFX2  = 5;
    localparam int T_XRD   = 3;
    localparam int T_XWR   = 4;
    localparam int T_GAP   = 5;
    localparam int T_REF   = 2;
    localparam int T_MAX   = 5;
    localparam int TCW     = $clog2(T_MAX + 1);
    localparam int FLAG_Z  = 6;
    localparam int FLAG_N  = 1;

    typedef enum logic [2:0] {
        S_IDLE, S_PFX1, S_PFX2, S_XRD, S_XWR, S_GAP
    } phase_t;
endpackage

// File: rtl/blkio_regs.sv
module blkio_regs
    import blkio_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              step,
    input  logic              dir_in,
    input  logic [ADDR_W-1:0] hl_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [DATA_W-1:0] c_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              dir,
    output logic [ADDR_W-1:0] hl,
    output logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] c,
    output logic [DATA_W-1:0] flags,
    output logic [DATA_W-1:0] latch,
    output logic              b_one
);
    assign b_one = (b == DATA_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= 1'b0;
            hl    <= '0;
            b     <= '0;
            c     <= '0;
            flags <= '0;
            latch <= '0;
        end else begin
            if (load) begin
                dir   <= dir_in;
                hl    <= hl_in;
                b     <= b_in;
                c     <= c_in;
                flags <= flags_in;
            end
            if (capture) begin
                latch <= data_in;
            end
            if (step) begin
                hl            <= hl - ADDR_W'(1);
                b             <= b - DATA_W'(1);
                flags[FLAG_Z] <= b_one;
                flags[FLAG_N] <= 1'b1;
            end
        end
    end

    // R3: each step lowers both pointer and counter by one
    p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (b == $past(b) - DATA_W'(1)) && (hl == $past(hl) - ADDR_W'(1)));

    // R8: zero flag follows the counter after a step
    p_zflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (flags[FLAG_Z] == (b == '0)) && flags[FLAG_N]);
endmodule

// File: rtl/blkio_fsm.sv
module blkio_fsm
    import blkio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic b_one,
    input  logic int_req,
    output logic busy,
    output logic load,
    output logic capture,
    output logic step,
    output logic rd_ph,
    output logic wr_ph,
    output logic refresh,
    output logic iter_end,
    output logic done,
    output logic restart
);
    phase_t         state, nxt;
    logic [TCW-1:0] tcnt;
    logic [TCW-1:0] len;
    logic           last;

    always_comb begin
        unique case (state)
            S_IDLE: len = TCW'(1);
            S_PFX1: len = TCW'(T_PFX1);
            S_PFX2: len = TCW'(T_PFX2);
            S_XRD:  len = TCW'(T_XRD);
            S_XWR:  len = TCW'(T_XWR);
            S_GAP:  len = TCW'(T_GAP);
            default: len = TCW'(1);
        endcase
    end

    assign last = (tcnt == len - TCW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_PFX1;
            S_PFX1: nxt = S_PFX2;
            S_PFX2: nxt = S_XRD;
            S_XRD:  nxt = S_XWR;
            S_XWR:  nxt = b_one ? S_IDLE : S_GAP;
            S_GAP:  nxt = int_req ? S_IDLE : S_PFX1;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            tcnt  <= '0;
        end else if (state == S_IDLE) begin
            state <= nxt;
            tcnt  <= '0;
        end else if (last) begin
            state <= nxt;
            tcnt  <= '0;
        end else begin
            tcnt  <= tcnt + TCW'(1);
        end
    end

    always_comb begin
        busy     = (state != S_IDLE);
        load     = (state == S_IDLE) && start;
        rd_ph    = (state == S_XRD);
        wr_ph    = (state == S_XWR);
        capture  = rd_ph && last;
        step     = wr_ph && last;
        done     = step && b_one;
        iter_end = (state == S_GAP) && last;
        restart  = iter_end && int_req;
        refresh  = (state == S_GAP) && (tcnt < TCW'(T_REF));
    end

    // R9: the block is idle right after done
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R6: refresh only inside a running gap, never with completion
    p_refresh_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> busy && !done && !rd_ph && !wr_ph);

    // R7: after a restart the block no longer runs
    p_restart_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !busy);
endmodule

// File: rtl/blkio_seq.sv
module blkio_seq
    import blkio_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_in,
    input  logic [AW-1:0] hl_in,
    input  logic [DW-1:0] b_in,
    input  logic [DW-1:0] c_in,
    input  logic [DW-1:0] flags_in,
    input  logic          int_req,
    input  logic [DW-1:0] data_in,
    output logic          io_rd,
    output logic          io_wr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          refresh,
    output logic [AW-1:0] io_addr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] data_out,
    output logic          busy,
    output logic          iter_end,
    output logic          done,
    output logic          restart,
    output logic [AW-1:0] hl_out,
    output logic [DW-1:0] b_out,
    output logic [DW-1:0] flags_out
);
    logic          load, capture, step, rd_ph, wr_ph, b_one, dir;
    logic [DW-1:0] c_reg, latch;

    blkio_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .b_one   (b_one),
        .int_req (int_req),
        .busy    (busy),
        .load    (load),
        .capture (capture),
        .step    (step),
        .rd_ph   (rd_ph),
        .wr_ph   (wr_ph),
        .refresh (refresh),
        .iter_end(iter_end),
        .done    (done),
        .restart (restart)
    );

    blkio_regs #(.DATA_W(DW), .ADDR_W(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .capture (capture),
        .step    (step),
        .dir_in  (dir_in),
        .hl_in   (hl_in),
        .b_in    (b_in),
        .c_in    (c_in),
        .flags_in(flags_in),
        .data_in (data_in),
        .dir     (dir),
        .hl      (hl_out),
        .b       (b_out),
        .c       (c_reg),
        .flags   (flags_out),
        .latch   (latch),
        .b_one   (b_one)
    );

    always_comb begin
        io_rd    = rd_ph && dir;
        mem_rd   = rd_ph && !dir;
        mem_wr   = wr_ph && dir;
        io_wr    = wr_ph && !dir;
        io_addr  = {b_out, c_reg};
        mem_addr = hl_out;
        data_out = latch;
    end

    // R2: strobes never overlap
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr, mem_rd, mem_wr, refresh}));

    // R1: address and data hold for the whole write
    p_wr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> $stable(mem_addr) && $stable(data_out));

    // R4: an interrupt window only opens while bytes remain
    p_window_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iter_end |-> (b_out != '0));
endmodule

// File: tb/blkio_seq_bench.sv
`timescale 1ns/1ps
module blkio_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_in = 1'b0, int_req = 1'b0;
    logic [15:0] hl_in = '0;
    logic [7:0]  b_in = '0, c_in = '0, flags_in = '0, data_in;
    logic        io_rd, io_wr, mem_rd, mem_wr, refresh, busy, iter_end, done, restart;
    logic [15:0] io_addr, mem_addr, hl_out;
    logic [7:0]  data_out, b_out, flags_out;

    always #2 clk = ~clk;

    blkio_seq u_blkio_seq (.*);

    function automatic logic [7:0] port_dev(input logic [15:0] a);
        return (a[15:8] * 8'd3) ^ a[7:0] ^ 8'hA5;
    endfunction
    function automatic logic [7:0] mem_dev(input logic [15:0] a);
        return (a[7:0] + a[15:8]) ^ 8'h3C;
    endfunction

    always_comb begin
        if (io_rd)       data_in = port_dev(io_addr);
        else if (mem_rd) data_in = mem_dev(mem_addr);
        else             data_in = 8'h00;
    end

    typedef struct packed { logic [1:0] kind; logic [15:0] addr; logic [7:0] data; } item_t;
    localparam logic [1:0] K_IORD = 2'd0, K_IOWR = 2'd1, K_MRD = 2'd2, K_MWR = 2'd3;
    item_t exp_q[$];

    int checks = 0, fails = 0;
    int cyc_busy = 0, n_ref = 0, n_done = 0, n_rst = 0, n_wr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic take(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
        item_t e;
        string tag;
        tag = (k == K_IORD || k == K_MWR) ? "R1 transfer" : "R2 transfer";
        if (exp_q.size() == 0) begin
            chk(1'b0, {tag, " unexpected"}, {14'd0, k, a}, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == k && e.addr == a, {tag, " kind/addr"}, {14'd0, k, a}, {14'd0, e.kind, e.addr});
            if (k == K_IOWR || k == K_MWR) begin
                n_wr++;
                chk(e.data == d, {tag, " data"}, d, e.data);
            end
        end
    endtask

    logic p_iord = 0, p_iowr = 0, p_mrd = 0, p_mwr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) cyc_busy++;
            if (refresh) n_ref++;
            if (done) n_done++;
            if (restart) n_rst++;
            if (io_rd && !p_iord)  take(K_IORD, io_addr, 8'h00);
            if (mem_rd && !p_mrd)  take(K_MRD, mem_addr, 8'h00);
            if (io_wr && !p_iowr)  take(K_IOWR, io_addr, data_out);
            if (mem_wr && !p_mwr)  take(K_MWR, mem_addr, data_out);
        end
        p_iord = io_rd; p_iowr = io_wr; p_mrd = mem_rd; p_mwr = mem_wr;
    end

    task automatic run_xfer(input logic d, input logic [15:0] hl0, input logic [7:0] b0,
                            input logic [7:0] c0, input logic [7:0] f0, input logic irq,
                            input int exp_n, input bit exp_rst, input bit poke, input string tag);
        logic [15:0] hl;
        logic [7:0]  b, fexp;
        int          exp_cyc, exp_ref;
        hl = hl0; b = b0;
        for (int k = 0; k < exp_n; k++) begin
            if (d) begin
                exp_q.push_back('{K_IORD, {b, c0}, 8'h00});
                exp_q.push_back('{K_MWR, hl, port_dev({b, c0})});
            end else begin
                exp_q.push_back('{K_MRD, hl, 8'h00});
                exp_q.push_back('{K_IOWR, {b, c0}, mem_dev(hl)});
            end
            hl = hl - 16'd1; b = b - 8'd1;
        end
        exp_cyc = exp_rst ? 21 * exp_n : 21 * (exp_n - 1) + 16;
        exp_ref = exp_rst ? 2 * exp_n : 2 * (exp_n - 1);
        fexp = f0; fexp[6] = (b == 8'd0); fexp[1] = 1'b1;

        @(negedge clk);
        cyc_busy = 0; n_ref = 0; n_done = 0; n_rst = 0; n_wr = 0;
        int_req = irq;
        start = 1'b1; dir_in = d; hl_in = hl0; b_in = b0; c_in = c0; flags_in = f0;
        @(negedge clk);
        start = 1'b0; hl_in = 16'hDEAD; b_in = 8'h77; c_in = 8'h99; dir_in = ~d;
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done || restart)) @(negedge clk);
        @(negedge clk);
        int_req = 1'b0;
        chk(!busy, {tag, " R9 busy low after end"}, busy, 0);
        chk(hl_out == hl && b_out == b, {tag, " R3 final HL/B"}, {hl_out, b_out}, {hl, b});
        chk(n_wr == exp_n, {tag, " R4 transfer count"}, n_wr, exp_n);
        chk(exp_q.size() == 0, {tag, " R1 R2 queue drained"}, exp_q.size(), 0);
        chk(cyc_busy == exp_cyc, {tag, " R5 busy cycles"}, cyc_busy, exp_cyc);
        chk(n_ref == exp_ref, {tag, " R6 refresh cycles"}, n_ref, exp_ref);
        chk(n_rst == (exp_rst ? 1 : 0), {tag, " R7 restart count"}, n_rst, exp_rst ? 1 : 0);
        chk(n_done == (exp_rst ? 0 : 1), {tag, " R9 done count"}, n_done, exp_rst ? 0 : 1);
        chk(flags_out == fexp, {tag, " R8 flags"}, flags_out, fexp);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !restart, "R11 reset idle", {busy, done, restart}, 0);
        chk(!io_rd && !io_wr && !mem_rd && !mem_wr && !refresh, "R11 reset strobes",
            {io_rd, io_wr, mem_rd, mem_wr, refresh}, 0);
        run_xfer(1'b1, 16'h4000, 8'd3, 8'h12, 8'h01, 1'b0, 3, 1'b0, 1'b0, "in3");
        run_xfer(1'b0, 16'h8123, 8'd5, 8'hA7, 8'hFE, 1'b0, 5, 1'b0, 1'b0, "out5");
        run_xfer(1'b1, 16'h1234, 8'd1, 8'h40, 8'h00, 1'b1, 1, 1'b0, 1'b0, "in1 R7 irq ignored");
        run_xfer(1'b0, 16'h0001, 8'd4, 8'h05, 8'h81, 1'b0, 4, 1'b0, 1'b0, "out wrap");
        run_xfer(1'b0, 16'h2000, 8'd0, 8'h33, 8'h55, 1'b0, 256, 1'b0, 1'b0, "out256");
        run_xfer(1'b1, 16'h6000, 8'd4, 8'h21, 8'hC3, 1'b1, 1, 1'b1, 1'b0, "in irq stop");
        run_xfer(1'b1, hl_out, b_out, 8'h21, 8'hC3, 1'b0, 3, 1'b0, 1'b0, "in irq resume");
        run_xfer(1'b1, 16'h7777, 8'd4, 8'h0F, 8'h00, 1'b0, 4, 1'b0, 1'b1, "R10 start while busy");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule